// File: doc/BRIEF.md
# Rotating-Connectivity Approximate Spike Counter

This block estimates how many presynaptic spikes reach one neuron of a sparse, randomly wired network. It keeps a single connectivity bit vector in a register. The wiring of every neuron is derived from that vector by a cyclic rotation, so no connectivity memory is needed. The spike vector of the previous time step is held in a register. The rotated connectivity is ANDed with it, and the set bits are counted.

Counting takes two stages. Each small group of adjacent synapse bits feeds a cheap counter that clamps at a ceiling. An exact, pipelined adder tree then sums the clamped group counts. In a sparse network a group rarely holds more set bits than the ceiling, so the result is normally exact. When a group does exceed the ceiling, the result falls short by a bounded amount.

The rotation source is a parameter. In barrel mode the rotation equals the neuron index supplied with each start pulse. In step mode a rotation register advances by one position per start, for neurons that are visited strictly in order.

Top module: `rot_spike_counter`

## Requirements
- R1: A synchronous reset clears the valid flag in every pipeline stage, clears the stored spike vector to zero and loads the stored connectivity from the parameter `CONN`. `cnt_vld` is low in the cycle after reset, and a start before any spike load yields a count of 0.
- R2: In barrel mode, the connectivity used for neuron index i has bit j equal to `CONN[(j - i) mod N]`, i.e. the stored vector rotated toward higher bit positions by i.
- R3: The active synapses are the bitwise AND of the rotated connectivity and the stored spike vector. The stored spike vector is replaced by `spk_in` on every clock edge at which `spk_load` is high.
- R4: When `spk_load` and `start` are sampled at the same edge, the count uses the spike vector stored before that edge. The newly loaded vector first affects the next start.
- R5: Group g covers active bits g*G to g*G+G-1. Its contribution is min(popcount, SAT), with G = 8 and SAT = 3 by default.
- R6: `cnt_out` is the exact sum of all group contributions and never exceeds (N/G)*SAT. When no group exceeds SAT, it equals the exact popcount of the active synapses.
- R7: The result and `cnt_vld` appear log2(N/G)+1 clock edges after the edge that samples `start` (4 by default). `cnt_vld` is high only for started neurons. Starts in consecutive cycles give one result per cycle, in order.
- R8: In step mode `nrn_idx` is ignored. The k-th start after reset (counting from 0) uses a rotation of k mod N.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| spk_load | input | 1 | Store `spk_in` as the spike vector of the time step |
| spk_in | input | N | Spike vector, one bit per presynaptic neuron |
| start | input | 1 | Begin a count for one neuron |
| nrn_idx | input | log2(N) | Neuron index, which sets the rotation in barrel mode |
| cnt_out | output | log2((N/G)*SAT+1) | Approximate spike count |
| cnt_vld | output | 1 | `cnt_out` holds a result |

## Verification
Two functions can fall in the same cycle: storing a new spike vector and starting a count that must still see the old one. The bench drives `spk_load` and `start` together, with vectors that differ between consecutive time steps. It then judges the result against a model that stores the new vector only after it has computed the count. Runs of back-to-back starts with random loads overlap these events with results that are still in the pipeline. Every result is compared with a clamp-per-group model, and unsaturated results are also compared with the exact popcount. A second instance in step mode sees the same stimulus and is checked against a start counter.

// File: rtl/spc_pkg.sv
package spc_pkg;

   typedef enum logic {ROT_BARREL = 1'b0, ROT_STEP = 1'b1} rot_mode_e;

   // bits needed to hold values 0..maxv
   function automatic int unsigned cnt_bits(input int unsigned maxv);
      return (maxv < 1) ? 1 : $clog2(maxv + 1);
   endfunction

endpackage

// File: rtl/spc_rotator.sv
module spc_rotator #(
   parameter int                  N    = 64,
   parameter logic [N-1:0]        CONN = '0,
   parameter spc_pkg::rot_mode_e  ROT  = spc_pkg::ROT_BARREL,
   localparam int                 IDXW = $clog2(N)
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            adv,
   input  logic [IDXW-1:0] idx,
   output logic [N-1:0]    rot
);

   logic [N-1:0] conn_q;

   // stored vector: fixed in barrel mode, advances one place per start in step mode
   always_ff @(posedge clk) begin
      if (rst)
         conn_q <= CONN;
      else if (ROT == spc_pkg::ROT_STEP && adv)
         conn_q <= {conn_q[N-2:0], conn_q[N-1]};
   end

   generate
      if (ROT == spc_pkg::ROT_BARREL) begin : g_barrel
         logic [2*N-1:0] dbl;
         always_comb begin
            dbl = {conn_q, conn_q} << idx;
            rot = dbl[2*N-1:N];
         end
      end else begin : g_step
         assign rot = conn_q;
      end
   endgenerate

endmodule

// File: rtl/spc_sat_group.sv
module spc_sat_group #(
   parameter int G   = 8,
   parameter int SAT = 3,
   parameter int W   = 2
) (
   input  logic [G-1:0] bits,
   output logic [W-1:0] cnt
);

   int c;

   always_comb begin
      c = 0;
      for (int i = 0; i < G; i++)
         c = c + int'(bits[i]);
      cnt = (c > SAT) ? W'(SAT) : W'(c);
   end

endmodule

// File: rtl/spc_add_tree.sv
module spc_add_tree #(
   parameter int NG = 8,
   parameter int IW = 2,
   parameter int OW = 5,
   localparam int L = $clog2(NG)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             in_vld,
   input  logic [NG*IW-1:0] in_dat,
   output logic             out_vld,
   output logic [OW-1:0]    out_dat
);

   generate
      for (genvar k = 0; k <= L; k++) begin : lv
         localparam int M = NG >> k;
         logic [OW-1:0] s [M];
         logic          v;
         if (k == 0) begin : g_in
            always_ff @(posedge clk) begin
               if (rst) v <= 1'b0;
               else     v <= in_vld;
               for (int m = 0; m < M; m++)
                  s[m] <= OW'(in_dat[m*IW +: IW]);
            end
         end else begin : g_sum
            always_ff @(posedge clk) begin
               if (rst) v <= 1'b0;
               else     v <= lv[k-1].v;
               for (int m = 0; m < M; m++)
                  s[m] <= lv[k-1].s[2*m] + lv[k-1].s[2*m+1];
            end
         end
      end
   endgenerate

   assign out_vld = lv[L].v;
   assign out_dat = lv[L].s[0];

endmodule

// File: rtl/rot_spike_counter.sv
module rot_spike_counter #(
   parameter int                  N    = 64,
   parameter int                  G    = 8,
   parameter int                  SAT  = 3,
   parameter logic [N-1:0]        CONN = 64'h7E04_F000_8120_0C91,
   parameter spc_pkg::rot_mode_e  ROT  = spc_pkg::ROT_BARREL,
   localparam int                 NG   = N / G,
   localparam int                 GW   = spc_pkg::cnt_bits(SAT),
   localparam int                 SUMW = spc_pkg::cnt_bits(NG * SAT),
   localparam int                 IDXW = $clog2(N)
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            spk_load,
   input  logic [N-1:0]    spk_in,
   input  logic            start,
   input  logic [IDXW-1:0] nrn_idx,
   output logic [SUMW-1:0] cnt_out,
   output logic            cnt_vld
);

   generate
      if (N % G != 0) begin : g_bad_grp
         $error("N must be a multiple of G");
      end
      if (NG < 2 || (NG & (NG - 1)) != 0) begin : g_bad_ng
         $error("N/G must be a power of two and at least 2");
      end
      if (SAT < 1 || SAT > G) begin : g_bad_sat
         $error("SAT must lie in 1..G");
      end
   endgenerate

   logic [N-1:0]     spk_q;
   logic [N-1:0]     conn_rot;
   logic [N-1:0]     act;
   logic [NG*GW-1:0] grp;

   always_ff @(posedge clk) begin
      if (rst)           spk_q <= '0;
      else if (spk_load) spk_q <= spk_in;
   end

   spc_rotator #(.N(N), .CONN(CONN), .ROT(ROT)) u_rot (
      .clk (clk),
      .rst (rst),
      .adv (start),
      .idx (nrn_idx),
      .rot (conn_rot)
   );

   assign act = conn_rot & spk_q;

   generate
      for (genvar g = 0; g < NG; g++) begin : g_grp
         spc_sat_group #(.G(G), .SAT(SAT), .W(GW)) u_grp (
            .bits (act[g*G +: G]),
            .cnt  (grp[g*GW +: GW])
         );
      end
   endgenerate

   spc_add_tree #(.NG(NG), .IW(GW), .OW(SUMW)) u_tree (
      .clk     (clk),
      .rst     (rst),
      .in_vld  (start),
      .in_dat  (grp),
      .out_vld (cnt_vld),
      .out_dat (cnt_out)
   );

endmodule

// File: rtl/spc_checker.sv
module spc_checker #(
   parameter int NG   = 8,
   parameter int SAT  = 3,
   parameter int SUMW = 5,
   localparam int LAT = $clog2(NG) + 1
) (
   input logic            clk,
   input logic            rst,
   input logic            start,
   input logic            cnt_vld,
   input logic [SUMW-1:0] cnt_out
);

   logic [LAT-1:0] sh;

   always_ff @(posedge clk) begin
      if (rst) sh <= '0;
      else     sh <= {sh[LAT-2:0], start};
   end

   AST_RST_CLEARS_VLD: assert property (@(posedge clk) rst |=> !cnt_vld); // R1

   AST_VLD_LATENCY: assert property (@(posedge clk) disable iff (rst)
      cnt_vld == sh[LAT-1]); // R7

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
      cnt_vld |-> (int'(cnt_out) <= NG * SAT)); // R6

   AST_CNT_KNOWN: assert property (@(posedge clk) disable iff (rst)
      cnt_vld |-> !$isunknown(cnt_out)); // R7

endmodule

bind rot_spike_counter spc_checker #(.NG(NG), .SAT(SAT), .SUMW(SUMW)) u_chk (
   .clk     (clk),
   .rst     (rst),
   .start   (start),
   .cnt_vld (cnt_vld),
   .cnt_out (cnt_out)
);

// File: tb/rot_spike_counter_bench.sv
`timescale 1ns/1ps
module rot_spike_counter_bench;

   localparam int          N    = 64;
   localparam int          G    = 8;
   localparam int          SAT  = 3;
   localparam int          NG   = N / G;
   localparam int          LAT  = 4;
   localparam logic [63:0] CONN = 64'h7E04_F000_8120_0C91;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        spk_load = 1'b0;
   logic [63:0] spk_in = '0;
   logic        start = 1'b0;
   logic [5:0]  nrn_idx = '0;
   logic [4:0]  cnt_out, cnt_out_s;
   logic        cnt_vld, cnt_vld_s;

   int    n_tests = 0;
   int    n_fail  = 0;
   int    sat_seen = 0;
   string cur_req = "R1";

   always #10 clk = ~clk;

   rot_spike_counter #(.N(N), .G(G), .SAT(SAT), .CONN(CONN),
                       .ROT(spc_pkg::ROT_BARREL)) u_rot_spike_counter (
      .clk(clk), .rst(rst), .spk_load(spk_load), .spk_in(spk_in),
      .start(start), .nrn_idx(nrn_idx), .cnt_out(cnt_out), .cnt_vld(cnt_vld));

   rot_spike_counter #(.N(N), .G(G), .SAT(SAT), .CONN(CONN),
                       .ROT(spc_pkg::ROT_STEP)) u_rot_spike_counter_step (
      .clk(clk), .rst(rst), .spk_load(spk_load), .spk_in(spk_in),
      .start(start), .nrn_idx(nrn_idx), .cnt_out(cnt_out_s), .cnt_vld(cnt_vld_s));

   // reference: rotate, AND, clamp per group, sum
   function automatic int ref_cnt(input int sh, input logic [63:0] spk, input bit exact);
      int total = 0;
      for (int g = 0; g < NG; g++) begin
         int c = 0;
         for (int b = 0; b < G; b++) begin
            int j = g * G + b;
            if (CONN[(j - sh + N) % N] && spk[j]) c++;
         end
         total += (!exact && c > SAT) ? SAT : c;
      end
      return total;
   endfunction

   logic [63:0] m_spk;
   int          step_pos;
   bit          e_v [LAT];
   int          e_cnt [LAT];
   int          e_ex [LAT];
   int          s_cnt [LAT];

   always @(posedge clk) begin
      if (rst) begin
         m_spk = '0;
         step_pos = 0;
         for (int k = 0; k < LAT; k++) e_v[k] = 1'b0;
      end else begin
         for (int k = LAT - 1; k > 0; k--) begin
            e_v[k] = e_v[k-1]; e_cnt[k] = e_cnt[k-1];
            e_ex[k] = e_ex[k-1]; s_cnt[k] = s_cnt[k-1];
         end
         e_v[0] = start;
         if (start) begin
            e_cnt[0] = ref_cnt(int'(nrn_idx), m_spk, 1'b0);
            e_ex[0]  = ref_cnt(int'(nrn_idx), m_spk, 1'b1);
            s_cnt[0] = ref_cnt(step_pos, m_spk, 1'b0);
            step_pos = (step_pos + 1) % N;
         end
         if (spk_load) m_spk = spk_in;   // after the count: old vector used (R4)
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (!rst) begin
         chk({cur_req, " valid"}, int'(cnt_vld), int'(e_v[LAT-1]));
         chk("R8 valid", int'(cnt_vld_s), int'(e_v[LAT-1]));
         if (e_v[LAT-1]) begin
            chk({cur_req, " count"}, int'(cnt_out), e_cnt[LAT-1]);
            chk("R8 count", int'(cnt_out_s), s_cnt[LAT-1]);
            if (e_ex[LAT-1] == e_cnt[LAT-1])
               chk("R6 exact", int'(cnt_out), e_ex[LAT-1]);
            else
               sat_seen++;
         end
      end
   end

   task automatic cyc(input bit ld, input logic [63:0] v, input bit st, input int idx);
      @(negedge clk);
      spk_load = ld; spk_in = v; start = st; nrn_idx = 6'(idx);
   endtask

   task automatic drain();
      for (int k = 0; k < LAT + 2; k++) cyc(1'b0, '0, 1'b0, 0);
   endtask

   initial begin
      #(20 * 200000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      // R1: idle after reset, start on empty spike register gives 0
      cur_req = "R1";
      cyc(1'b0, '0, 1'b0, 0);
      cyc(1'b0, '0, 1'b1, 5);
      drain();
      // R2: single spike bit, several rotations
      cur_req = "R2";
      for (int j = 0; j < N; j += 9) begin
         cyc(1'b1, 64'd1 << j, 1'b0, 0);
         for (int i = 0; i < N; i += 7) cyc(1'b0, '0, 1'b1, i);
      end
      drain();
      // R5: all spikes set, dense groups saturate
      cur_req = "R5";
      cyc(1'b1, '1, 1'b0, 0);
      for (int i = 0; i < 20; i++) cyc(1'b0, '0, 1'b1, i);
      drain();
      // R3/R6: sparse random spikes
      cur_req = "R6";
      for (int t = 0; t < 40; t++) begin
         cyc(1'b1, {$urandom & $urandom & $urandom, $urandom & $urandom & $urandom}, 1'b0, 0);
         cyc(1'b0, '0, 1'b1, int'($urandom % N));
         cyc(1'b0, '0, 1'b1, int'($urandom % N));
      end
      drain();
      // R4: load and start in the same cycle
      cur_req = "R4";
      cyc(1'b1, 64'h00FF_0000_FFFF_0F0F, 1'b0, 0);
      for (int t = 0; t < 30; t++)
         cyc(1'b1, {$urandom, $urandom}, 1'b1, int'($urandom % N));
      drain();
      // R3/R7: back-to-back starts with random loads
      cur_req = "R7";
      for (int t = 0; t < 300; t++)
         cyc(1'(($urandom % 3) == 0), {$urandom & $urandom, $urandom | $urandom},
             1'(($urandom % 4) != 0), int'($urandom % N));
      drain();
      // R5: saturation must have occurred at least once
      n_tests++;
      if (sat_seen == 0) begin
         n_fail++;
         $display("FAIL R5 saturation: actual %0d expected >0", sat_seen);
      end
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule